// File: doc/BRIEF.md
# Interrupt Acceptance and Deferral Controller

This block decides, cycle by cycle, whether a processor core may enter an interrupt handler. It sits between a set of interrupt request lines and the instruction sequencer. The sequencer reports each instruction that retires. It also reports the decoded return-from-interrupt, enable, disable and lock instructions. In return it receives a one-cycle take strobe and the index of the handler to enter. An interrupt can only be entered on a retire cycle, so the current instruction always finishes first. Entering a handler masks further interrupts until software re-enables them.

Requests are captured on their rising edge and stay pending while interrupts are masked. When interrupts go from masked to enabled, a guard lets one more instruction retire before any pending request is taken. This keeps a storm of requests from starving the background code. A lock command defers all interrupts for exactly sixteen retired instructions. After that the deferral ends by itself and a waiting request is taken with no further software action. When several requests are pending, the one with the lowest index is served first.

Top module: `irq_gate`

## Requirements
- R1: `take_o` is high only in a cycle in which `retire_i` is high.
- R2: While `gie_o` is low, `take_o` stays low. The cycle after a take, `gie_o` is low. A request line that stays high after its take does not raise a second take.
- R3: A cycle with `reti_i` or `ei_i` high sets `gie_o` from the next cycle on. A cycle with `di_i` high clears it from the next cycle on. When disable and enable occur together, disable wins. When a take and an enable occur together, the take wins and `gie_o` goes low.
- R4: A rising edge on `irq_i[k]` makes request k pending from the next cycle on. The request is held while interrupts are masked, and it is cleared only when it is taken.
- R5: After `gie_o` goes from low to high, the first retire cycle never takes an interrupt. A pending request can be taken from the second retire cycle on.
- R6: After a cycle with `lock_i` high, the next 16 retire cycles take no interrupt. The 17th retire cycle takes a pending request with no further command. Cycles without a retire do not count toward the 16.
- R7: A lock issued while a lock is active reloads the count to 16, also when it coincides with a retire.
- R8: Among pending requests, the lowest index wins. `vec_o` carries that index, as a binary number, during the take cycle. `take_o` never stays high for two cycles in a row.
- R9: Reset leaves `gie_o` low and `take_o` low. It also clears all pending requests, the lock count and the post-enable guard.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | An instruction retires this cycle (instruction boundary) |
| irq_i | input | NUM_IRQ | Interrupt request lines, captured on rising edge |
| reti_i | input | 1 | Return-from-interrupt decoded this cycle |
| ei_i | input | 1 | Enable-interrupts instruction decoded this cycle |
| di_i | input | 1 | Disable-interrupts instruction decoded this cycle |
| lock_i | input | 1 | Lock instruction: defer interrupts for LOCK_LEN retires |
| take_o | output | 1 | Enter the handler now (one-cycle pulse) |
| vec_o | output | $clog2(NUM_IRQ) | Index of the request being taken |
| gie_o | output | 1 | Global interrupt-enable state |

## Verification
`take_o` and `vec_o` are combinational and are due in the same cycle as the retire that allows the take. `gie_o` is due one cycle after the enable, disable, return or take that changes it. A rising request edge becomes eligible for a take only one cycle after it arrives. The bench drives every input just after a falling edge and samples the outputs one nanosecond later, before the next rising edge. Each sample therefore shows the take decision for the driven cycle and the enable state left by the edges before it. The lock tests count retire cycles one by one and expect the take on exactly the 17th.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    localparam int unsigned DEF_NUM_IRQ  = 4;
    localparam int unsigned DEF_LOCK_LEN = 16;

    // enable/guard sequencing state
    typedef enum logic [1:0] {
        GATE_MASKED = 2'd0,  // interrupts disabled
        GATE_ARMING = 2'd1,  // enabled, one retire still owed to background
        GATE_OPEN   = 2'd2   // enabled, takes allowed
    } gate_state_e;

    // decoded strobes from the sequencer for one cycle
    typedef struct packed {
        logic retire;
        logic reti;
        logic en;
        logic dis;
        logic lock;
    } seq_cmd_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned len);
        return $clog2(len + 1);
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int unsigned NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic [NUM_IRQ-1:0] clr_i,
    output logic [NUM_IRQ-1:0] pend_o
);
    logic [NUM_IRQ-1:0] irq_q;
    logic [NUM_IRQ-1:0] rise;

    assign rise = irq_i & ~irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= '0;
            pend_o <= '0;
        end else begin
            irq_q  <= irq_i;
            pend_o <= (pend_o & ~clr_i) | rise;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned NUM_IRQ = 4,
    localparam int unsigned IW = irq_gate_pkg::idx_width(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] pend_i,
    output logic [NUM_IRQ-1:0] grant_o,
    output logic [IW-1:0]      idx_o,
    output logic               any_o
);
    logic [NUM_IRQ:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chain
        assign grant_o[g]  = pend_i[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | pend_i[g];
    end

    assign any_o = seen[NUM_IRQ];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (grant_o[i]) idx_o = idx_o | IW'(i);
        end
    end
endmodule

// File: rtl/irq_lock_count.sv
module irq_lock_count #(
    parameter int unsigned LOCK_LEN = 16,
    localparam int unsigned CW = irq_gate_pkg::cnt_width(LOCK_LEN)
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_i,
    input  logic retire_i,
    output logic busy_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (lock_i) begin
            cnt_q <= CW'(LOCK_LEN);
        end else if (retire_i && cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_gate_pkg::*;
#(
    parameter int unsigned NUM_IRQ  = DEF_NUM_IRQ,
    parameter int unsigned LOCK_LEN = DEF_LOCK_LEN,
    localparam int unsigned IW = idx_width(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               retire_i,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               reti_i,
    input  logic               ei_i,
    input  logic               di_i,
    input  logic               lock_i,
    output logic               take_o,
    output logic [IW-1:0]      vec_o,
    output logic               gie_o
);
    seq_cmd_t           cmd;
    gate_state_e        state_q, state_d;
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] grant;
    logic [NUM_IRQ-1:0] clr;
    logic               any_pend;
    logic               lock_busy;

    assign cmd = '{retire: retire_i, reti: reti_i, en: ei_i, dis: di_i, lock: lock_i};

    irq_edge_latch #(.NUM_IRQ(NUM_IRQ)) i_latch (
        .clk    (clk),
        .rst    (rst),
        .irq_i  (irq_i),
        .clr_i  (clr),
        .pend_o (pend_q)
    );

    irq_prio_pick #(.NUM_IRQ(NUM_IRQ)) i_pick (
        .pend_i  (pend_q),
        .grant_o (grant),
        .idx_o   (vec_o),
        .any_o   (any_pend)
    );

    irq_lock_count #(.LOCK_LEN(LOCK_LEN)) i_lock (
        .clk      (clk),
        .rst      (rst),
        .lock_i   (cmd.lock),
        .retire_i (cmd.retire),
        .busy_o   (lock_busy)
    );

    // take only at a boundary, when fully open and not locked
    assign take_o = cmd.retire && (state_q == GATE_OPEN) && !lock_busy && any_pend;
    assign clr    = take_o ? grant : '0;
    assign gie_o  = (state_q != GATE_MASKED);

    always_comb begin
        state_d = state_q;
        if (take_o || cmd.dis) begin
            state_d = GATE_MASKED;
        end else begin
            case (state_q)
                GATE_MASKED: if (cmd.en || cmd.reti) state_d = GATE_ARMING;
                GATE_ARMING: if (cmd.retire) state_d = GATE_OPEN;
                GATE_OPEN:   state_d = GATE_OPEN;
                default:     state_d = GATE_MASKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GATE_MASKED;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
    parameter int unsigned NUM_IRQ = 4,
    localparam int unsigned IW = irq_gate_pkg::idx_width(NUM_IRQ)
) (
    input logic               clk,
    input logic               rst,
    input logic               retire_i,
    input logic               reti_i,
    input logic               di_i,
    input logic               lock_i,
    input logic               take_o,
    input logic [IW-1:0]      vec_o,
    input logic               gie_o,
    input logic [NUM_IRQ-1:0] pend
);
    logic [NUM_IRQ-1:0] below;

    always_comb begin
        below = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (IW'(i) < vec_o) below[i] = 1'b1;
        end
    end

    AST_TAKE_ON_RETIRE: assert property (@(posedge clk) disable iff (rst) take_o |-> retire_i); // R1
    AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (rst) take_o |=> !gie_o); // R2
    AST_MASKED_NO_TAKE: assert property (@(posedge clk) disable iff (rst) !gie_o |-> !take_o); // R2
    AST_DIS_MASKS: assert property (@(posedge clk) disable iff (rst) di_i |=> !gie_o); // R3
    AST_RETI_OPENS: assert property (@(posedge clk) disable iff (rst) (reti_i && !di_i && !take_o) |=> gie_o); // R3
    AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (rst) take_o |-> pend[vec_o]); // R4
    AST_GUARD_FIRST: assert property (@(posedge clk) disable iff (rst) $rose(gie_o) |-> !take_o); // R5
    AST_LOCK_DEFERS: assert property (@(posedge clk) disable iff (rst) lock_i |=> !take_o); // R6
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst) take_o |-> ((pend & below) == '0)); // R8
    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (rst) take_o |=> !take_o); // R8
endmodule

bind irq_gate irq_gate_chk #(.NUM_IRQ(NUM_IRQ)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .retire_i (retire_i),
    .reti_i   (reti_i),
    .di_i     (di_i),
    .lock_i   (lock_i),
    .take_o   (take_o),
    .vec_o    (vec_o),
    .gie_o    (gie_o),
    .pend     (pend_q)
);

// File: tb/test_irq_gate.sv
`timescale 1ns/1ps
module test_irq_gate;
    localparam int N = 4;
    localparam int ROWS = 27;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic retire_i = 0, reti_i = 0, ei_i = 0, di_i = 0, lock_i = 0;
    logic [N-1:0] irq_i = '0;
    logic take_o, gie_o;
    logic [1:0] vec_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_gate i_irq_gate (
        .clk(clk), .rst(rst), .retire_i(retire_i), .irq_i(irq_i),
        .reti_i(reti_i), .ei_i(ei_i), .di_i(di_i), .lock_i(lock_i),
        .take_o(take_o), .vec_o(vec_o), .gie_o(gie_o)
    );

    // {req[3:0], ret, irq[3:0], reti, en, dis, lock, take, vec[1:0], gie}
    localparam logic [16:0] TBL [0:ROWS-1] = '{
        {4'd9, 13'b0_0000_0000_0_00_0},  // R9 reset state
        {4'd4, 13'b1_0010_0000_0_00_0},  // R4 edge while masked
        {4'd2, 13'b1_0010_0000_0_00_0},  // R2 masked, pending held
        {4'd3, 13'b1_0010_0100_0_00_0},  // R3 enable
        {4'd5, 13'b1_0010_0000_0_00_1},  // R5 guard retire
        {4'd4, 13'b1_0010_0000_1_01_1},  // R4 held request taken
        {4'd2, 13'b1_0010_0000_0_00_0},  // R2 level high, masked
        {4'd3, 13'b1_1001_1000_0_00_0},  // R3 return sets enable
        {4'd1, 13'b0_1001_0000_0_00_1},  // R1 no retire
        {4'd5, 13'b1_1001_0000_0_00_1},  // R5 guard retire
        {4'd1, 13'b0_1001_0000_0_00_1},  // R1 no retire, no take
        {4'd8, 13'b1_1001_0000_1_00_1},  // R8 lowest of 0,3
        {4'd3, 13'b0_1001_0110_0_00_0},  // R3 en+dis
        {4'd3, 13'b1_1001_0000_0_00_0},  // R3 disable won
        {4'd3, 13'b0_1001_0100_0_00_0},  // R3 enable
        {4'd5, 13'b1_1001_0010_0_00_1},  // R5 guard, with disable
        {4'd3, 13'b0_1001_0000_0_00_0},  // R3 disabled
        {4'd3, 13'b0_1001_1000_0_00_0},  // R3 return
        {4'd5, 13'b1_1001_0000_0_00_1},  // R5 guard
        {4'd8, 13'b1_1001_0100_1_11_1},  // R8 take index 3 with enable
        {4'd3, 13'b1_1001_0000_0_00_0},  // R3 take beat enable
        {4'd3, 13'b1_1001_1000_0_00_0},  // R3 return
        {4'd5, 13'b1_1001_0000_0_00_1},  // R5 guard
        {4'd4, 13'b1_1001_0000_0_00_1},  // R4 held levels not re-pended
        {4'd4, 13'b0_0110_0000_0_00_1},  // R4 edges 1,2
        {4'd8, 13'b1_0110_0000_1_01_1},  // R8 lowest of 1,2
        {4'd2, 13'b0_0110_0000_0_00_0}   // R2 masked after take
    };

    task automatic step(input logic ret, input logic [N-1:0] irq,
                        input logic rt, input logic en, input logic ds, input logic lk);
        @(negedge clk);
        retire_i = ret; irq_i = irq; reti_i = rt; ei_i = en; di_i = ds; lock_i = lk;
        #1;
    endtask

    task automatic expect_out(input string req, input logic tk, input logic [1:0] vc, input logic ge);
        checks++;
        if (take_o !== tk) begin
            fails++;
            $display("FAIL %s take_o actual=%b expected=%b t=%0t", req, take_o, tk, $time);
        end
        checks++;
        if (gie_o !== ge) begin
            fails++;
            $display("FAIL %s gie_o actual=%b expected=%b t=%0t", req, gie_o, ge, $time);
        end
        if (tk) begin
            checks++;
            if (vec_o !== vc) begin
                fails++;
                $display("FAIL %s vec_o actual=%0d expected=%0d t=%0t", req, vec_o, vc, $time);
            end
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired, run hung");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int r = 0; r < ROWS; r++) begin
            logic [16:0] v;
            v = TBL[r];
            step(v[12], v[11:8], v[7], v[6], v[5], v[4]);
            expect_out($sformatf("R%0d row %0d", v[16:13], r), v[3], v[2:1], v[0]);
        end

        // R6: pending index 2 waits out a lock of 16 retires
        step(0, 4'b0110, 1, 0, 0, 0);
        expect_out("R6 return", 0, 0, 0);
        step(0, 4'b0110, 0, 0, 0, 1);
        expect_out("R6 lock", 0, 0, 1);
        for (int k = 0; k < 16; k++) begin
            step(1, 4'b0110, 0, 0, 0, 0);
            expect_out("R6 locked retire", 0, 0, 1);
            if (k == 7) begin
                for (int j = 0; j < 3; j++) begin
                    step(0, 4'b0110, 0, 0, 0, 0);
                    expect_out("R6 idle not counted", 0, 0, 1);
                end
            end
        end
        step(1, 4'b0110, 0, 0, 0, 0);
        expect_out("R6 17th retire", 1, 2, 1);
        step(0, 4'b0110, 0, 0, 0, 0);
        expect_out("R6 masked after", 0, 0, 0);

        // R7: relock with a retire reloads to 16
        step(0, 4'b0000, 0, 0, 0, 0);
        step(0, 4'b0001, 0, 0, 0, 0);
        step(0, 4'b0001, 1, 0, 0, 0);
        step(0, 4'b0001, 0, 0, 0, 1);
        expect_out("R7 first lock", 0, 0, 1);
        for (int k = 0; k < 10; k++) begin
            step(1, 4'b0001, 0, 0, 0, 0);
            expect_out("R7 locked", 0, 0, 1);
        end
        step(1, 4'b0001, 0, 0, 0, 1);
        expect_out("R7 relock on retire", 0, 0, 1);
        for (int k = 0; k < 16; k++) begin
            step(1, 4'b0001, 0, 0, 0, 0);
            expect_out("R7 reloaded", 0, 0, 1);
        end
        step(1, 4'b0001, 0, 0, 0, 0);
        expect_out("R7 take after reload", 1, 0, 1);

        // R9: reset clears pending and lock
        step(0, 4'b0000, 0, 0, 0, 0);
        step(0, 4'b0010, 0, 0, 0, 0);
        step(0, 4'b0010, 0, 0, 0, 1);
        @(negedge clk);
        rst = 1'b1; irq_i = '0; lock_i = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        expect_out("R9 after reset", 0, 0, 0);
        step(0, 4'b1000, 0, 0, 0, 0);
        step(0, 4'b1000, 0, 1, 0, 0);
        expect_out("R9 enable", 0, 0, 0);
        step(1, 4'b1000, 0, 0, 0, 0);
        expect_out("R9 guard", 0, 0, 1);
        step(1, 4'b1000, 0, 0, 0, 0);
        expect_out("R9 old pending and lock gone", 1, 3, 1);
        step(0, 4'b1000, 0, 0, 0, 0);

        done = 1;
        finish_run();
    end
endmodule